// File: doc/BRIEF.md
# Segment Access Limit Checker

This block validates a single memory access against one cached segment descriptor. Each transaction presents the descriptor's base, its 20-bit raw limit, the granularity, expand-down and default-size flags, the code/data kind, one access-right bit and a null marker. It also presents the access: an offset, a length, a kind (read, write or fetch) and a mode flag that selects the legacy 32-bit rules or the 64-bit rules. The block returns the linear address and a fault flag with a cause code.

The check takes one register stage behind a valid/ready handshake. A result stays on the outputs until the consumer takes it, so the block can sit between an address-generation stage and a paging stage without extra buffering. In legacy mode it scales the limit by granularity, checks normal and expand-down ranges on both the first and the last byte, flags accesses that wrap past 4 GiB, checks access rights and rejects null segments. In 64-bit mode only the access-right check is made, and the base applies only to the two segments that keep one.

Top module: `seg_access_chk`

## Requirements
- R1: The effective limit is the raw limit zero-extended when `seg_gran`=0, and the raw limit followed by twelve 1 bits when `seg_gran`=1.
- R2: In legacy mode, for a normal segment (`seg_expdn`=0), the access faults with cause 1 (limit) unless the first byte (offset) and the last byte (offset + `acc_len_m1`) both lie in [0, effective limit].
- R3: In legacy mode, for an expand-down segment, the access faults with cause 1 unless the first byte is above the effective limit and the last byte is at or below the upper bound. The upper bound is FFFFh when `seg_big`=0 and FFFFFFFFh when `seg_big`=1.
- R4: In legacy mode, an access whose last byte would pass FFFFFFFFh (offset + `acc_len_m1` overflowing 32 bits) faults with cause 1, whatever the segment kind.
- R5: Access kinds are encoded 0 = read, 1 = write, 2 = fetch. The following fault with cause 2 (type): a write to a code segment (`seg_code`=1), a write to a data segment with `seg_rw`=0, a read from a code segment with `seg_rw`=0, and a fetch from a data segment.
- R6: In legacy mode, an access with `seg_null`=1 faults with cause 3 (null). The priority is null over type over limit.
- R7: In 64-bit mode (`mode64`=1), no null or limit fault is raised, but type faults still are. The linear address is the 64-bit offset plus the base when `seg_fsgs`=1, or the offset alone when `seg_fsgs`=0, modulo 2^64.
- R8: In legacy mode the linear address is (low 32 bits of base + low 32 bits of offset) modulo 2^32, zero-extended to 64 bits.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`. An accepted access appears on the outputs with `out_valid`=1 in the cycle after acceptance, and the outputs hold unchanged while `out_valid`=1 and `out_ready`=0.
- R10: A synchronous reset clears `out_valid`. Whenever `out_valid`=1, `fault` is 1 exactly when `cause` is non-zero (0 = ok).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Access request valid |
| in_ready | output | 1 | Block can accept a request |
| seg_base | input | 64 | Segment base address |
| seg_lim_raw | input | 20 | Raw segment limit |
| seg_gran | input | 1 | Page granularity for the limit |
| seg_expdn | input | 1 | Expand-down data segment |
| seg_big | input | 1 | Default-size flag selecting the expand-down upper bound |
| seg_code | input | 1 | 1 = code segment, 0 = data segment |
| seg_rw | input | 1 | Readable (code) or writable (data) |
| seg_null | input | 1 | Segment register holds a null selector |
| seg_fsgs | input | 1 | Segment keeps its base in 64-bit mode |
| acc_off | input | 64 | Access offset |
| acc_len_m1 | input | 4 | Access length in bytes minus one |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| mode64 | input | 1 | 1 = 64-bit rules, 0 = legacy rules |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| lin_addr | output | 64 | Linear address |
| fault | output | 1 | Access faults |
| cause | output | 2 | 0 ok, 1 limit, 2 type, 3 null |

## Verification
A mistake in the limit scaling or in the range compare shows as a wrong cause on the very result of the access that hits the boundary, so the bench probes offsets at the limit and at the upper bound, one byte on each side, and lengths that straddle them. A corrupted result register or a broken hold condition shows while the consumer stalls: the outputs change or `in_ready` rises during the stall cycles themselves. An error in the mode or priority selection shows as the wrong one of several simultaneous faults in the cycle after acceptance.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_OK    = 2'd0,
    CAUSE_LIMIT = 2'd1,
    CAUSE_TYPE  = 2'd2,
    CAUSE_NULL  = 2'd3
  } cause_e;
endpackage

// File: rtl/seg_limit_unit.sv
// Legacy-mode range check on first and last byte (R1..R4)
module seg_limit_unit #(
  parameter int LEG_W   = 32,
  parameter int RAW_W   = 20,
  parameter int GRAN_SH = 12,
  parameter int LEN_W   = 4,
  parameter int SMALL_W = 16
) (
  input  logic [RAW_W-1:0] lim_raw,
  input  logic             gran,
  input  logic             expdn,
  input  logic             big,
  input  logic [LEG_W-1:0] off,
  input  logic [LEN_W-1:0] len_m1,
  output logic             lim_bad
);
  localparam int EXT_W = LEG_W + 1;

  logic [LEG_W-1:0] eff_lim;
  logic [LEG_W-1:0] upper;
  logic [EXT_W-1:0] last_ext;
  logic [LEG_W-1:0] last_b;
  logic             wrap;

  always_comb begin
    eff_lim  = gran ? LEG_W'({lim_raw, {GRAN_SH{1'b1}}}) : LEG_W'(lim_raw);
    upper    = big ? {LEG_W{1'b1}} : LEG_W'({SMALL_W{1'b1}});
    last_ext = {1'b0, off} + EXT_W'(len_m1);
    wrap     = last_ext[LEG_W];
    last_b   = last_ext[LEG_W-1:0];
    if (wrap)
      lim_bad = 1'b1;
    else if (expdn)
      lim_bad = (off <= eff_lim) || (last_b > upper);
    else
      lim_bad = (last_b > eff_lim);
  end
endmodule

// File: rtl/seg_type_unit.sv
// Access-right check (R5)
module seg_type_unit
  import seg_chk_pkg::*;
(
  input  logic       is_code,
  input  logic       rw_ok,
  input  logic [1:0] kind,
  output logic       type_bad
);
  always_comb begin
    unique case (acc_kind_e'(kind))
      KIND_READ:  type_bad = is_code && !rw_ok;
      KIND_WRITE: type_bad = is_code || !rw_ok;
      KIND_FETCH: type_bad = !is_code;
      default:    type_bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/seg_addr_gen.sv
// Linear address formation (R7, R8)
module seg_addr_gen #(
  parameter int LIN_W = 64,
  parameter int LEG_W = 32
) (
  input  logic [LIN_W-1:0] base,
  input  logic [LIN_W-1:0] off,
  input  logic             mode64,
  input  logic             keep_base,
  output logic [LIN_W-1:0] lin
);
  logic [LEG_W-1:0] leg_sum;

  always_comb begin
    leg_sum = base[LEG_W-1:0] + off[LEG_W-1:0];
    if (mode64)
      lin = off + (keep_base ? base : '0);
    else
      lin = LIN_W'(leg_sum);
  end
endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
  import seg_chk_pkg::*;
#(
  parameter int LIN_W   = 64,
  parameter int LEG_W   = 32,
  parameter int RAW_W   = 20,
  parameter int GRAN_SH = 12,
  parameter int LEN_W   = 4,
  parameter int SMALL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LIN_W-1:0] seg_base,
  input  logic [RAW_W-1:0] seg_lim_raw,
  input  logic             seg_gran,
  input  logic             seg_expdn,
  input  logic             seg_big,
  input  logic             seg_code,
  input  logic             seg_rw,
  input  logic             seg_null,
  input  logic             seg_fsgs,
  input  logic [LIN_W-1:0] acc_off,
  input  logic [LEN_W-1:0] acc_len_m1,
  input  logic [1:0]       acc_kind,
  input  logic             mode64,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LIN_W-1:0] lin_addr,
  output logic             fault,
  output logic [1:0]       cause
);
  logic             lim_bad;
  logic             type_bad;
  logic [LIN_W-1:0] lin_d;
  cause_e           cause_d;
  logic             take;

  seg_limit_unit #(
    .LEG_W(LEG_W), .RAW_W(RAW_W), .GRAN_SH(GRAN_SH),
    .LEN_W(LEN_W), .SMALL_W(SMALL_W)
  ) u_limit (
    .lim_raw (seg_lim_raw),
    .gran    (seg_gran),
    .expdn   (seg_expdn),
    .big     (seg_big),
    .off     (acc_off[LEG_W-1:0]),
    .len_m1  (acc_len_m1),
    .lim_bad (lim_bad)
  );

  seg_type_unit u_type (
    .is_code  (seg_code),
    .rw_ok    (seg_rw),
    .kind     (acc_kind),
    .type_bad (type_bad)
  );

  seg_addr_gen #(.LIN_W(LIN_W), .LEG_W(LEG_W)) u_addr (
    .base      (seg_base),
    .off       (acc_off),
    .mode64    (mode64),
    .keep_base (seg_fsgs),
    .lin       (lin_d)
  );

  // Fault priority: null, then type, then limit; 64-bit mode skips null/limit
  always_comb begin
    if (!mode64 && seg_null)      cause_d = CAUSE_NULL;
    else if (type_bad)            cause_d = CAUSE_TYPE;
    else if (!mode64 && lim_bad)  cause_d = CAUSE_LIMIT;
    else                          cause_d = CAUSE_OK;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      lin_addr  <= '0;
      fault     <= 1'b0;
      cause     <= CAUSE_OK;
    end else begin
      if (in_ready)
        out_valid <= in_valid;
      if (take) begin
        lin_addr <= lin_d;
        fault    <= (cause_d != CAUSE_OK);
        cause    <= cause_d;
      end
    end
  end
endmodule

// File: rtl/seg_access_chk_sva.sv
module seg_access_chk_sva #(
  parameter int LIN_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             seg_null,
  input logic             mode64,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LIN_W-1:0] lin_addr,
  input logic             fault,
  input logic [1:0]       cause
);
  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(lin_addr) && $stable(cause) && $stable(fault)));

  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R6
  null_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !mode64 && seg_null) |=> (cause == 2'd3));

  // R7
  m64_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mode64) |=> (cause != 2'd1 && cause != 2'd3));

  // R10
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (fault == (cause != 2'd0)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind seg_access_chk seg_access_chk_sva #(.LIN_W(LIN_W)) u_sva (.*);

// File: tb/seg_access_chk_bench.sv
module seg_access_chk_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] seg_base = '0;
  logic [19:0] seg_lim_raw = '0;
  logic        seg_gran = 0, seg_expdn = 0, seg_big = 0, seg_code = 0;
  logic        seg_rw = 0, seg_null = 0, seg_fsgs = 0, mode64 = 0;
  logic [63:0] acc_off = '0;
  logic [3:0]  acc_len_m1 = '0;
  logic [1:0]  acc_kind = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] lin_addr;
  logic        fault;
  logic [1:0]  cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seg_access_chk u_seg_access_chk (.*);

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] eff_limit();
    return seg_gran ? {seg_lim_raw, 12'hFFF} : {12'h0, seg_lim_raw};
  endfunction

  function automatic logic [1:0] exp_cause();
    logic [32:0] last;
    logic [31:0] ub;
    logic tb, lb;
    last = {1'b0, acc_off[31:0]} + {29'b0, acc_len_m1};
    ub = seg_big ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    if (last[32]) lb = 1;
    else if (seg_expdn) lb = !(acc_off[31:0] > eff_limit()) || (last[31:0] > ub);
    else lb = last[31:0] > eff_limit();
    case (acc_kind)
      2'd0: tb = seg_code && !seg_rw;
      2'd1: tb = seg_code || !seg_rw;
      2'd2: tb = !seg_code;
      default: tb = 1;
    endcase
    if (!mode64 && seg_null) return 2'd3;
    if (tb) return 2'd2;
    if (!mode64 && lb) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [63:0] exp_lin();
    logic [31:0] s;
    if (mode64) return acc_off + (seg_fsgs ? seg_base : 64'd0);
    s = seg_base[31:0] + acc_off[31:0];
    return {32'd0, s};
  endfunction

  task automatic run(input string rq, input int stall);
    logic [1:0]  ec;
    logic [63:0] el;
    ec = exp_cause();
    el = exp_lin();
    in_valid  = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R9 valid after accept", {63'd0, out_valid}, 64'd1);
    chk(cause === ec, rq, {62'd0, cause}, {62'd0, ec});
    chk(lin_addr === el, mode64 ? "R7 lin" : "R8 lin", lin_addr, el);
    chk(fault === (ec != 0), "R10 fault flag", {63'd0, fault}, {63'd0, ec != 0});
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(in_ready === 1'b0, "R9 ready low in stall", {63'd0, in_ready}, 64'd0);
      chk(cause === ec && lin_addr === el && out_valid === 1'b1, "R9 hold",
          {62'd0, cause}, {62'd0, ec});
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 drain", {63'd0, out_valid}, 64'd0);
    chk(in_ready === 1'b1, "R9 ready after drain", {63'd0, in_ready}, 64'd1);
    out_ready = 1'b0;
  endtask

  task automatic set_seg(input logic [63:0] b, input logic [19:0] l, input bit g, input bit e,
                         input bit big, input bit code, input bit rw, input bit nul, input bit fg);
    seg_base = b; seg_lim_raw = l; seg_gran = g; seg_expdn = e; seg_big = big;
    seg_code = code; seg_rw = rw; seg_null = nul; seg_fsgs = fg;
  endtask

  task automatic set_acc(input logic [63:0] o, input logic [3:0] l, input logic [1:0] k, input bit m);
    acc_off = o; acc_len_m1 = l; acc_kind = k; mode64 = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid === 1'b0, "R10 reset valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1, "R9 ready idle", {63'd0, in_ready}, 64'd1);

    // R1 R2 byte granularity boundaries
    set_seg(64'h1000, 20'h00FFF, 0, 0, 0, 0, 1, 0, 0);
    set_acc(64'hFFE, 4'd1, 2'd0, 0); run("R2 last byte at limit", 0);
    set_acc(64'hFFF, 4'd1, 2'd0, 0); run("R2 last byte past limit", 2);
    set_acc(64'h1000, 4'd0, 2'd1, 0); run("R1 R2 first byte past limit", 0);
    // R1 page granularity
    set_seg(64'h0, 20'h00001, 1, 0, 0, 0, 1, 0, 0);
    set_acc(64'h1FFF, 4'd0, 2'd0, 0); run("R1 scaled limit top", 0);
    set_acc(64'h2000, 4'd0, 2'd0, 0); run("R1 scaled limit past", 0);
    // R3 expand-down, small bound
    set_seg(64'h0, 20'h00100, 0, 1, 0, 0, 1, 0, 0);
    set_acc(64'h100, 4'd0, 2'd0, 0); run("R3 at limit faults", 0);
    set_acc(64'h101, 4'd0, 2'd1, 0); run("R3 above limit ok", 0);
    set_acc(64'hFFFE, 4'd1, 2'd0, 0); run("R3 ends at FFFF ok", 0);
    set_acc(64'hFFFF, 4'd1, 2'd0, 0); run("R3 past FFFF faults", 0);
    // R3 expand-down, big bound
    set_seg(64'h0, 20'h00100, 0, 1, 1, 0, 1, 0, 0);
    set_acc(64'hFFFF_FFF0, 4'd15, 2'd0, 0); run("R3 big bound top ok", 1);
    // R4 wrap
    set_seg(64'h0, 20'hFFFFF, 1, 0, 0, 0, 1, 0, 0);
    set_acc(64'hFFFF_FFFF, 4'd1, 2'd0, 0); run("R4 wrap normal", 0);
    set_seg(64'h0, 20'h00100, 0, 1, 1, 0, 1, 0, 0);
    set_acc(64'hFFFF_FFFE, 4'd3, 2'd0, 0); run("R4 wrap expand-down", 0);
    // R5 types
    set_seg(64'h0, 20'hFFFFF, 1, 0, 0, 1, 1, 0, 0);
    set_acc(64'h10, 4'd0, 2'd1, 0); run("R5 write code", 0);
    set_acc(64'h10, 4'd0, 2'd0, 0); run("R5 read readable code", 0);
    set_seg(64'h0, 20'hFFFFF, 1, 0, 0, 1, 0, 0, 0);
    set_acc(64'h10, 4'd0, 2'd0, 0); run("R5 read execute-only", 0);
    set_acc(64'h10, 4'd0, 2'd2, 0); run("R5 fetch execute-only ok", 0);
    set_seg(64'h0, 20'hFFFFF, 1, 0, 0, 0, 0, 0, 0);
    set_acc(64'h10, 4'd0, 2'd1, 0); run("R5 write read-only data", 0);
    set_acc(64'h10, 4'd0, 2'd2, 0); run("R5 fetch data", 0);
    // R6 null priority over type and limit
    set_seg(64'h0, 20'h00000, 0, 0, 0, 1, 0, 1, 0);
    set_acc(64'h5000, 4'd3, 2'd1, 0); run("R6 null priority", 0);
    set_seg(64'h0, 20'h00000, 0, 0, 0, 1, 0, 0, 0);
    set_acc(64'h5000, 4'd3, 2'd1, 0); run("R6 type over limit", 0);
    // R7 64-bit mode
    set_seg(64'h1234_0000_0000, 20'h0, 0, 0, 0, 0, 1, 1, 0);
    set_acc(64'hFFFF_8000_0000_0010, 4'd7, 2'd0, 1); run("R7 no null no limit", 0);
    set_seg(64'h1234_0000_0000, 20'h0, 0, 0, 0, 0, 1, 0, 1);
    set_acc(64'h0000_7000_0000_0010, 4'd7, 2'd1, 1); run("R7 fs-gs base", 1);
    set_seg(64'h0, 20'h0, 0, 0, 0, 1, 1, 0, 0);
    set_acc(64'h40, 4'd0, 2'd1, 1); run("R7 type still checked", 0);
    // R8 legacy wrap of address
    set_seg(64'hABCD_0000_FFFF_F000, 20'hFFFFF, 1, 0, 0, 0, 1, 0, 0);
    set_acc(64'h5555_0000_0000_2000, 4'd0, 2'd0, 0); run("R8 legacy sum", 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] pick, el;
      set_seg({$urandom, $urandom}, 20'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), ($urandom % 8) == 0, 1'($urandom));
      el = eff_limit();
      pick = $urandom % 4;
      case (pick)
        0: acc_off = {$urandom, $urandom};
        1: acc_off = {$urandom, el + 32'($signed(5'($urandom)))};
        2: acc_off = {$urandom, (seg_big ? 32'hFFFF_FFFF : 32'hFFFF) - 32'($urandom % 20)};
        default: acc_off = {32'd0, 32'($urandom % 64)};
      endcase
      acc_len_m1 = 4'($urandom);
      acc_kind = 2'($urandom % 3);
      mode64 = ($urandom % 4) == 0;
      run("R2 R3 R5 R6 R7 random", int'($urandom % 3));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule